// File: doc/BRIEF.md
# Prioritized Interrupt and Serial-Bit Controller

This block sits beside an 8-bit processor core and decides which of five interrupt request lines is served next. The lines differ in how they trigger. The highest-priority line is non-maskable and needs both a rising edge and a level that is still high. The second line is edge-triggered and keeps its edge in a latch until the edge is served or cleared. The third and fourth lines count only while they are held high. The fifth line is a general-purpose level request that has no built-in target. The block presents the winning request with a source code and a restart address. The core answers with a one-cycle acknowledge, which clears the edge latch of the source being served.

The block also carries a single serial output bit and samples a single serial input bit. The core reaches both, and the three source masks, through two paths. The first is a configuration word written over a valid/ready port. The ready output is tied high, so a word is taken on every cycle in which valid is high and the port never applies back-pressure. The second is an 8-bit status word that always shows the current masks, the global enable, the pending sources and the serial input level. A plain global-enable input gates every source except the non-maskable one.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the serial output is 0, the three masks are all set (masked), both edge latches are clear and no request is presented. With all inputs low, the status word reads 0x07.
- R2: On an accepted configuration word with bit 6 = 1, bit 7 is copied into the serial output. With bit 6 = 0 the serial output keeps its value. The new value shows one cycle after acceptance.
- R3: Status bit 7 shows the serial input level, captured through one register. It follows the input one cycle late.
- R4: A configuration word with bit 3 = 1 loads its bits 2, 1 and 0 into the masks of the edge source, the upper level source and the lower level source, in that order (1 = masked). With bit 3 = 0 the masks keep their values. The masks read back in status bits 2..0.
- R5: Each level source requests one cycle after its input goes high, while it is unmasked and enabled, and stops once the input is low again. Status bits 5 (upper) and 4 (lower) show the captured input levels whether or not the source is masked.
- R6: A rising edge on the edge source is latched and requests two cycles after the edge. The request stays after the input falls, and it also survives masking until it is unmasked. Status bit 6 shows the latch. A configuration word with bit 4 = 1 clears the latch.
- R7: The non-maskable source ignores the masks and the global enable. It requests only when its edge latch is set and its input is still high. After it is acknowledged, an input that stays high raises no new request.
- R8: Priority from highest to lowest is non-maskable (code 0, address 0x0024), edge (code 1, 0x003C), upper level (code 2, 0x0034), lower level (code 3, 0x002C), general (code 4). When no request is valid, the code and the address both read 0.
- R9: With the global enable low, no source except the non-maskable one is presented. Status bit 3 shows the enable.
- R10: An acknowledge while a request is valid clears the edge latch of the winning source. It has no effect on a level source that is still high.
- R11: The general source requests with code 4 and address 0x0000 only when enabled and no higher source is pending.
- R12: The configuration port ready output is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nmi_req_i | input | 1 | Non-maskable request, edge and level qualified |
| edge_req_i | input | 1 | Rising-edge request |
| lvl_hi_req_i | input | 1 | Upper-priority level request |
| lvl_lo_req_i | input | 1 | Lower-priority level request |
| gen_req_i | input | 1 | General-purpose level request, no vector |
| gie_i | input | 1 | Global enable for the maskable sources |
| irq_ack_i | input | 1 | Acknowledge of the presented request |
| ser_in_i | input | 1 | Serial input bit |
| ser_out_o | output | 1 | Serial output latch |
| cfg_valid_i | input | 1 | Configuration word valid |
| cfg_ready_o | output | 1 | Configuration word ready (always 1) |
| cfg_data_i | input | 8 | Configuration word |
| stat_data_o | output | 8 | Status word |
| irq_valid_o | output | 1 | A request is presented |
| irq_src_o | output | 3 | Code of the winning source |
| irq_vector_o | output | 16 | Restart address of the winner |

## Verification
Each result has a fixed due cycle. A level request, a status level bit and the serial input bit arrive one clock after the input changes, because each passes one capture register. An edge-qualified request arrives two clocks after the edge, because it passes the capture register and then the edge latch. A configuration word, an acknowledge or a cleared latch takes effect one clock after the edge that accepts it. The global enable acts at once, since it gates the request combinationally. The bench drives inputs on the falling edge and samples on a later falling edge, counted as above. For the one- and two-cycle latencies it also checks the sample just before the due edge, to show that the output has not yet changed.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int unsigned NSRC  = 5;
  localparam int unsigned DW    = 8;
  localparam int unsigned VEC_W = 16;
  localparam int unsigned SRC_W = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_NMI    = 3'd0,
    SRC_EDGE   = 3'd1,
    SRC_LVL_HI = 3'd2,
    SRC_LVL_LO = 3'd3,
    SRC_GEN    = 3'd4
  } src_e;

  // configuration word, msb first
  typedef struct packed {
    logic       so_val;
    logic       so_en;
    logic       spare;
    logic       edge_clr;
    logic       mask_ld;
    logic [2:0] mask;
  } cfg_word_t;

  // status word, msb first
  typedef struct packed {
    logic       ser_in;
    logic       pend_edge;
    logic       pend_hi;
    logic       pend_lo;
    logic       gie;
    logic [2:0] mask;
  } stat_word_t;

  // mask bit positions
  localparam int unsigned MSK_EDGE = 2;
  localparam int unsigned MSK_HI   = 1;
  localparam int unsigned MSK_LO   = 0;

  // sources that pass through an edge latch
  localparam logic [NSRC-1:0] EDGE_SRCS = 5'b00011;

  // restart address: twice the restart number, times four
  function automatic logic [VEC_W-1:0] vec_of(input logic [SRC_W-1:0] s);
    int unsigned half_code;
    case (s)
      SRC_NMI:    half_code = 9;
      SRC_EDGE:   half_code = 15;
      SRC_LVL_HI: half_code = 13;
      SRC_LVL_LO: half_code = 11;
      default:    half_code = 0;
    endcase
    return VEC_W'(half_code * 4);
  endfunction
endpackage

// File: rtl/pirq_capture.sv
module pirq_capture #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         ser_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic         ser_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_cap
    logic cur_q;
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q     <= 1'b0;
        prev_q[g] <= 1'b0;
      end else begin
        cur_q     <= req_i[g];
        prev_q[g] <= cur_q;
      end
    end
    assign lvl_o[g]  = cur_q;
    assign rise_o[g] = cur_q & ~prev_q[g];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) ser_o <= 1'b0;
    else         ser_o <= ser_i;
  end
endmodule

// File: rtl/pirq_latch.sv
module pirq_latch #(
  parameter int unsigned     N        = 5,
  parameter logic [N-1:0]    EDGE_SET = '0
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [N-1:0] rise_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] held_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    if (EDGE_SET[g]) begin : g_edge
      logic held_q;
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni)        held_q <= 1'b0;
        else if (rise_i[g]) held_q <= 1'b1;
        else if (clr_i[g])  held_q <= 1'b0;
      end
      assign held_o[g] = held_q;
    end else begin : g_level
      assign held_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/pirq_cfg.sv
module pirq_cfg
  import pirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  cfg_word_t     word_i,
  output logic [2:0]    mask_o,
  output logic          ser_out_o,
  output logic          edge_clr_o
);
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o    <= 3'b111;
      ser_out_o <= 1'b0;
    end else if (fire_i) begin
      if (word_i.mask_ld) mask_o    <= word_i.mask;
      if (word_i.so_en)   ser_out_o <= word_i.so_val;
    end
  end

  assign edge_clr_o = fire_i & word_i.edge_clr;
endmodule

// File: rtl/pirq_arb.sv
module pirq_arb
  import pirq_pkg::*;
(
  input  logic [NSRC-1:0]  lvl_i,
  input  logic [NSRC-1:0]  held_i,
  input  logic [2:0]       mask_i,
  input  logic             gie_i,
  output logic [NSRC-1:0]  grant_o,
  output logic             valid_o,
  output logic [SRC_W-1:0] src_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [NSRC-1:0] qual;

  always_comb begin
    qual           = '0;
    qual[SRC_NMI]    = held_i[SRC_NMI] & lvl_i[SRC_NMI];
    qual[SRC_EDGE]   = held_i[SRC_EDGE] & ~mask_i[MSK_EDGE] & gie_i;
    qual[SRC_LVL_HI] = lvl_i[SRC_LVL_HI] & ~mask_i[MSK_HI] & gie_i;
    qual[SRC_LVL_LO] = lvl_i[SRC_LVL_LO] & ~mask_i[MSK_LO] & gie_i;
    qual[SRC_GEN]    = lvl_i[SRC_GEN] & gie_i;
  end

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    src_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && !found) begin
        found      = 1'b1;
        grant_o[i] = 1'b1;
        src_o      = SRC_W'(i);
      end
    end
    valid_o = found;
    vec_o   = found ? vec_of(src_o) : '0;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             nmi_req_i,
  input  logic             edge_req_i,
  input  logic             lvl_hi_req_i,
  input  logic             lvl_lo_req_i,
  input  logic             gen_req_i,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  input  logic             ser_in_i,
  output logic             ser_out_o,
  input  logic             cfg_valid_i,
  output logic             cfg_ready_o,
  input  logic [DW-1:0]    cfg_data_i,
  output logic [DW-1:0]    stat_data_o,
  output logic             irq_valid_o,
  output logic [SRC_W-1:0] irq_src_o,
  output logic [VEC_W-1:0] irq_vector_o
);
  logic [NSRC-1:0] req_raw, lvl, rise, held, clr, grant;
  logic [2:0]      mask_q;
  logic            ser_in_q, edge_clr, cfg_fire;
  stat_word_t      stat;

  assign req_raw[SRC_NMI]    = nmi_req_i;
  assign req_raw[SRC_EDGE]   = edge_req_i;
  assign req_raw[SRC_LVL_HI] = lvl_hi_req_i;
  assign req_raw[SRC_LVL_LO] = lvl_lo_req_i;
  assign req_raw[SRC_GEN]    = gen_req_i;

  assign cfg_ready_o = 1'b1;
  assign cfg_fire    = cfg_valid_i & cfg_ready_o;

  pirq_capture #(.N(NSRC)) u_cap (
    .clk    (clk),
    .rst_ni (rst_ni),
    .req_i  (req_raw),
    .ser_i  (ser_in_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .ser_o  (ser_in_q)
  );

  always_comb begin
    clr = grant & {NSRC{irq_ack_i & irq_valid_o}};
    clr[SRC_EDGE] = clr[SRC_EDGE] | edge_clr;
  end

  pirq_latch #(.N(NSRC), .EDGE_SET(EDGE_SRCS)) u_latch (
    .clk    (clk),
    .rst_ni (rst_ni),
    .rise_i (rise),
    .clr_i  (clr),
    .held_o (held)
  );

  pirq_cfg u_cfg (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .fire_i     (cfg_fire),
    .word_i     (cfg_word_t'(cfg_data_i)),
    .mask_o     (mask_q),
    .ser_out_o  (ser_out_o),
    .edge_clr_o (edge_clr)
  );

  pirq_arb u_arb (
    .lvl_i   (lvl),
    .held_i  (held),
    .mask_i  (mask_q),
    .gie_i   (gie_i),
    .grant_o (grant),
    .valid_o (irq_valid_o),
    .src_o   (irq_src_o),
    .vec_o   (irq_vector_o)
  );

  always_comb begin
    stat.ser_in    = ser_in_q;
    stat.pend_edge = held[SRC_EDGE];
    stat.pend_hi   = lvl[SRC_LVL_HI];
    stat.pend_lo   = lvl[SRC_LVL_LO];
    stat.gie       = gie_i;
    stat.mask      = mask_q;
  end
  assign stat_data_o = stat;
endmodule

// File: rtl/pirq_chk.sv
module pirq_chk (
  input logic        clk,
  input logic        rst_ni,
  input logic        cfg_valid_i,
  input logic [7:0]  cfg_data_i,
  input logic        ser_out_o,
  input logic        gie_i,
  input logic        irq_valid_o,
  input logic [2:0]  irq_src_o,
  input logic [15:0] irq_vector_o,
  input logic [2:0]  mask_q,
  input logic [4:0]  grant
);
  // R2
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cfg_valid_i && cfg_data_i[6]) |=> $stable(ser_out_o));
  // R8
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(grant));
  // R8
  nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_valid_o && irq_src_o == 3'd0) |-> irq_vector_o == 16'h0024);
  // R11
  gen_vec_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_valid_o && irq_src_o == 3'd4) |-> irq_vector_o == 16'h0000);
  // R4
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_valid_o && irq_src_o == 3'd2) |-> !mask_q[1]);
  // R9
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_valid_o && !gie_i) |-> irq_src_o == 3'd0);
endmodule

bind prio_irq_ctrl pirq_chk u_chk (
  .clk          (clk),
  .rst_ni       (rst_ni),
  .cfg_valid_i  (cfg_valid_i),
  .cfg_data_i   (cfg_data_i),
  .ser_out_o    (ser_out_o),
  .gie_i        (gie_i),
  .irq_valid_o  (irq_valid_o),
  .irq_src_o    (irq_src_o),
  .irq_vector_o (irq_vector_o),
  .mask_q       (mask_q),
  .grant        (grant)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, nmi, edg, lhi, llo, gen, gie, ack, sin, cfg_valid;
  logic [7:0]  cfg_data, stat;
  logic        sout, cfg_ready, irq_valid;
  logic [2:0]  irq_src;
  logic [15:0] irq_vec;
  int n_chk = 0, n_fail = 0;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_ni(rst_ni), .nmi_req_i(nmi), .edge_req_i(edg),
    .lvl_hi_req_i(lhi), .lvl_lo_req_i(llo), .gen_req_i(gen), .gie_i(gie),
    .irq_ack_i(ack), .ser_in_i(sin), .ser_out_o(sout),
    .cfg_valid_i(cfg_valid), .cfg_ready_o(cfg_ready), .cfg_data_i(cfg_data),
    .stat_data_o(stat), .irq_valid_o(irq_valid), .irq_src_o(irq_src),
    .irq_vector_o(irq_vec)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(logic [7:0] d);
    cfg_valid = 1'b1; cfg_data = d;
    tick(1);
    cfg_valid = 1'b0; cfg_data = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic irq_is(string req, logic v, logic [2:0] s, logic [15:0] vec);
    chk(req, "valid", irq_valid, v);
    chk(req, "src", irq_src, v ? s : 3'd0);
    chk(req, "vector", irq_vec, v ? vec : 16'h0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; tick(2); rst_ni = 1'b1; tick(1);
  endtask

  task automatic test_reset();
    chk("R1", "status", stat, 8'h07);
    chk("R1", "ser_out", sout, 1'b0);
    irq_is("R1", 1'b0, 3'd0, 16'h0);
    chk("R12", "ready", cfg_ready, 1'b1);
  endtask

  task automatic test_serial();
    cfg_write(8'hC0); chk("R2", "set with enable", sout, 1'b1);
    cfg_write(8'h00); chk("R2", "hold, enable low", sout, 1'b1);
    cfg_write(8'h80); chk("R2", "hold, bit7 only", sout, 1'b1);
    chk("R4", "masks untouched", stat[2:0], 3'b111);
    cfg_write(8'h40); chk("R2", "clear with enable", sout, 1'b0);
  endtask

  task automatic test_ser_in();
    sin = 1'b1;
    chk("R3", "before capture", stat[7], 1'b0);
    tick(1); chk("R3", "captured high", stat[7], 1'b1);
    sin = 1'b0; tick(1); chk("R3", "captured low", stat[7], 1'b0);
  endtask

  task automatic test_masks();
    cfg_write(8'h0D); chk("R4", "load 101", stat[2:0], 3'b101);
    cfg_write(8'h02); chk("R4", "no load bit", stat[2:0], 3'b101);
    cfg_write(8'h08); chk("R4", "load 000", stat[2:0], 3'b000);
  endtask

  task automatic test_level();
    gie = 1'b1;
    lhi = 1'b1;
    chk("R5", "not yet", irq_valid, 1'b0);
    tick(1); irq_is("R5", 1'b1, 3'd2, 16'h0034);
    chk("R5", "status hi", stat[5], 1'b1);
    lhi = 1'b0; tick(1); irq_is("R5", 1'b0, 3'd0, 16'h0);
    cfg_write(8'h0A);
    lhi = 1'b1; tick(1);
    irq_is("R5", 1'b0, 3'd0, 16'h0);
    chk("R5", "status shows masked level", stat[5], 1'b1);
    llo = 1'b1; tick(1);
    irq_is("R5", 1'b1, 3'd3, 16'h002C);
    gie = 1'b0; #1;
    irq_is("R9", 1'b0, 3'd0, 16'h0);
    chk("R9", "status gie", stat[3], 1'b0);
    gie = 1'b1; #1;
    chk("R9", "status gie on", stat[3], 1'b1);
    tick(0);
    do_ack();
    irq_is("R10", 1'b1, 3'd3, 16'h002C);
    lhi = 1'b0; llo = 1'b0;
    cfg_write(8'h08); tick(1);
  endtask

  task automatic test_edge();
    edg = 1'b1;
    tick(1); chk("R6", "one cycle", irq_valid, 1'b0);
    tick(1); irq_is("R6", 1'b1, 3'd1, 16'h003C);
    edg = 1'b0; tick(2);
    irq_is("R6", 1'b1, 3'd1, 16'h003C);
    chk("R6", "status latch", stat[6], 1'b1);
    cfg_write(8'h10);
    irq_is("R6", 1'b0, 3'd0, 16'h0);
    chk("R6", "latch cleared", stat[6], 1'b0);
    cfg_write(8'h0C);
    edg = 1'b1; tick(1); edg = 1'b0; tick(2);
    irq_is("R6", 1'b0, 3'd0, 16'h0);
    chk("R6", "masked latch held", stat[6], 1'b1);
    cfg_write(8'h08);
    irq_is("R6", 1'b1, 3'd1, 16'h003C);
    do_ack();
    irq_is("R10", 1'b0, 3'd0, 16'h0);
    edg = 1'b1; tick(3);
    irq_is("R10", 1'b1, 3'd1, 16'h003C);
    do_ack(); tick(2);
    irq_is("R10", 1'b0, 3'd0, 16'h0);
    edg = 1'b0; tick(1);
  endtask

  task automatic test_nmi();
    cfg_write(8'h0F); gie = 1'b0;
    nmi = 1'b1;
    tick(1); chk("R7", "one cycle", irq_valid, 1'b0);
    tick(1); irq_is("R7", 1'b1, 3'd0, 16'h0024);
    do_ack(); tick(2);
    irq_is("R7", 1'b0, 3'd0, 16'h0);
    nmi = 1'b0; tick(1);
    nmi = 1'b1; tick(1); nmi = 1'b0; tick(2);
    irq_is("R7", 1'b0, 3'd0, 16'h0);
    nmi = 1'b1; tick(2);
    irq_is("R7", 1'b1, 3'd0, 16'h0024);
    do_ack(); nmi = 1'b0; tick(1);
    gie = 1'b1; cfg_write(8'h08);
  endtask

  task automatic test_priority();
    lhi = 1'b1; llo = 1'b1; gen = 1'b1;
    tick(1); irq_is("R8", 1'b1, 3'd2, 16'h0034);
    edg = 1'b1; tick(2); irq_is("R8", 1'b1, 3'd1, 16'h003C);
    nmi = 1'b1; tick(2); irq_is("R8", 1'b1, 3'd0, 16'h0024);
    do_ack(); irq_is("R8", 1'b1, 3'd1, 16'h003C);
    do_ack(); irq_is("R8", 1'b1, 3'd2, 16'h0034);
    lhi = 1'b0; tick(1); irq_is("R8", 1'b1, 3'd3, 16'h002C);
    llo = 1'b0; tick(1); irq_is("R11", 1'b1, 3'd4, 16'h0000);
    gie = 1'b0; #1; irq_is("R11", 1'b0, 3'd0, 16'h0);
    gie = 1'b1; gen = 1'b0; edg = 1'b0; nmi = 1'b0;
    tick(1); irq_is("R11", 1'b0, 3'd0, 16'h0);
  endtask

  task automatic test_reset_midrun();
    cfg_write(8'hC8);
    edg = 1'b1; tick(2); edg = 1'b0; tick(1);
    chk("R1", "latch before reset", stat[6], 1'b1);
    gie = 1'b0;
    do_reset();
    chk("R1", "status after reset", stat, 8'h07);
    chk("R1", "ser_out after reset", sout, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; nmi = 0; edg = 0; lhi = 0; llo = 0; gen = 0;
    gie = 0; ack = 0; sin = 0; cfg_valid = 0; cfg_data = '0;
    @(negedge clk);
    do_reset();
    test_reset();
    test_serial();
    test_ser_in();
    test_masks();
    test_level();
    test_edge();
    test_nmi();
    test_priority();
    test_reset_midrun();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule